// File: doc/BRIEF.md
# MSI Request Generator with Per-Vector Masking

This block converts interrupt requests from an application into message-signalled interrupt writes for a PCIe endpoint. It reads its settings from configuration register values that are driven in from outside: the command register, the 32-bit dword that holds the MSI control half-word, the MSI address, the MSI data and one mask bit per vector. From these it produces a single-beat write request that carries an address and a data word. TLP framing, the link and legacy INTx signalling sit in other blocks.

An application asserts a request with a vector number. It holds the request until the block returns a one-cycle acknowledge with a two-bit status. There are three outcomes:
- The message is sent.
- The vector is masked. The request is then held as pending and is sent automatically once the mask clears.
- The request is dropped, because MSI is off or the vector lies outside the enabled range.

Pending vectors whose masks have cleared take priority over new requests. Among them, the lowest index is served first.

Top module: `msi_gen`

## Requirements
- R1: After synchronous reset, `app_ack` and `wr_valid` are low and every pending bit is cleared. Unmasking vectors after reset produces no write.
- R2: An accepted request produces exactly one write. `wr_valid` rises one cycle after the request is sampled. `wr_addr` equals `cfg_msi_addr`. `wr_data` equals `cfg_msi_data` ORed with the vector number, limited to its low log2(count) bits. In the same cycle `app_ack` is high with status 0 (sent).
- R3: When bit 16 of `cfg_msi_ctl` (MSI enable) is clear, a request is acknowledged with status 2 (dropped) and no write is issued.
- R4: Bits [22:20] of `cfg_msi_ctl` hold n, the multiple-message-enable field. The enabled vector count is 2^n, and values above 5 count as 32. A request whose vector is at or above the count is acknowledged with status 2 and issues no write.
- R5: A request for an in-range vector whose `cfg_msi_mask` bit is set issues no write. It is acknowledged with status 1 (held), and that vector's pending bit is set.
- R6: While MSI is enabled, a vector whose pending bit is set and whose mask bit is clear is sent one cycle later, with that vector's data. Its pending bit is cleared, so it is sent only once.
- R7: When several pending vectors are unmasked, they are sent one per cycle, lowest index first. A pending vector is sent before a live request. The live request waits, and is not acknowledged in that cycle.
- R8: `app_ack` is a one-cycle pulse. A request still held in the cycle its acknowledge is high is not served again.
- R9: Bit 10 of `cfg_cmd` (legacy interrupt disable) has no effect on MSI delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cmd | input | 16 | Command register value; bit 10 disables legacy interrupts |
| cfg_msi_ctl | input | 32 | MSI capability dword; bit 16 enable, bits [22:20] message-count exponent |
| cfg_msi_addr | input | 64 | Programmed MSI address |
| cfg_msi_data | input | 16 | Programmed MSI data |
| cfg_msi_mask | input | 32 | Per-vector mask bits |
| app_req | input | 1 | Request strobe, held until acknowledged |
| app_vec | input | 5 | Requested vector number |
| app_ack | output | 1 | One-cycle acknowledge |
| app_status | output | 2 | Outcome: 0 sent, 1 held pending, 2 dropped |
| wr_valid | output | 1 | Write request valid, one cycle per message |
| wr_addr | output | 64 | Write address |
| wr_data | output | 16 | Write data |

## Verification
The main sweep runs every multiple-message-enable code from 0 to 7 against every vector from 0 to 31. This separates in-range vectors, which are sent with the vector ORed into the data, from out-of-range vectors, which are dropped. It also shows that codes 6 and 7 clamp to 32 vectors. A run with the enable bit clear shows the drop path when no vector check applies. Masked-request patterns separate a held request from a sent one. Releasing two held vectors at once shows the lowest-index order. Releasing a held vector together with a live request shows that pending traffic comes first. Toggling the legacy-disable bit, and building a pending bit just before reset, show that neither affects later delivery.

// File: rtl/msi_gen_pkg.sv
package msi_gen_pkg;

    localparam int NUM_VEC          = 32;
    localparam int VEC_W            = $clog2(NUM_VEC);
    localparam int ADDR_W           = 64;
    localparam int DATA_W           = 16;
    localparam int CTL_EN_BIT       = 16;
    localparam int CTL_MME_LSB      = 20;
    localparam int CTL_MME_W        = 3;
    localparam int CMD_INTX_DIS_BIT = 10;

    typedef enum logic [1:0] {
        ST_SENT = 2'd0,
        ST_HELD = 2'd1,
        ST_DROP = 2'd2
    } msi_status_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } msi_wr_t;

    typedef struct packed {
        logic              ack;
        msi_status_e       status;
    } msi_resp_t;

    // Clamp the count exponent to the number of vector bits available.
    function automatic int unsigned mme_log(input logic [CTL_MME_W-1:0] mme);
        int unsigned v;
        v = int'(mme);
        return (v > VEC_W) ? VEC_W : v;
    endfunction

    // OR the vector number into the low bits permitted by the low-bit mask.
    function automatic logic [DATA_W-1:0] compose_data(
        input logic [DATA_W-1:0] base,
        input logic [VEC_W-1:0]  vec,
        input logic [VEC_W-1:0]  low_mask
    );
        logic [DATA_W-1:0] ext;
        ext = '0;
        ext[VEC_W-1:0] = vec & low_mask;
        return base | ext;
    endfunction

endpackage

// File: rtl/msi_vec_window.sv
module msi_vec_window
    import msi_gen_pkg::*;
#(
    parameter int N_VEC = NUM_VEC,
    parameter int V_W   = VEC_W
) (
    input  logic [31:0]      ctl_dw,
    output logic             msi_en,
    output logic [N_VEC-1:0] in_range,
    output logic [V_W-1:0]   low_mask
);
    logic [CTL_MME_W-1:0] mme;
    int unsigned          log_cnt;

    assign mme    = ctl_dw[CTL_MME_LSB +: CTL_MME_W];
    assign msi_en = ctl_dw[CTL_EN_BIT];

    always_comb log_cnt = mme_log(mme);

    genvar gi;
    generate
        for (gi = 0; gi < N_VEC; gi++) begin : g_rng
            assign in_range[gi] = (gi < (1 << log_cnt));
        end
        for (gi = 0; gi < V_W; gi++) begin : g_low
            assign low_mask[gi] = (gi < log_cnt);
        end
    endgenerate

endmodule

// File: rtl/msi_pend_arb.sv
module msi_pend_arb
    import msi_gen_pkg::*;
#(
    parameter int N_VEC = NUM_VEC,
    parameter int V_W   = VEC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [V_W-1:0]   set_idx,
    input  logic             clr_en,
    input  logic [V_W-1:0]   clr_idx,
    input  logic [N_VEC-1:0] release_ok,
    output logic             grant_valid,
    output logic [V_W-1:0]   grant_idx
);
    logic [N_VEC-1:0] pend_q;
    logic [N_VEC-1:0] pend_d;
    logic [N_VEC-1:0] elig;
    logic [N_VEC-1:0] set_vec;
    logic [N_VEC-1:0] clr_vec;

    genvar gi;
    generate
        for (gi = 0; gi < N_VEC; gi++) begin : g_bit
            assign set_vec[gi] = set_en && (set_idx == V_W'(gi));
            assign clr_vec[gi] = clr_en && (clr_idx == V_W'(gi));
            assign pend_d[gi]  = (pend_q[gi] & ~clr_vec[gi]) | set_vec[gi];
            assign elig[gi]    = pend_q[gi] & release_ok[gi];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    // Lowest index wins: scan downward so the last hit is the smallest.
    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        for (int i = N_VEC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant_valid = 1'b1;
                grant_idx   = V_W'(i);
            end
        end
    end

    AST_CLR_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> pend_q[clr_idx]);  // R6

    AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_vec));  // R6

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> ((elig & ((N_VEC'(1) << grant_idx) - N_VEC'(1))) == '0));  // R7

    AST_CLEARED_AFTER_SEND: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !pend_q[$past(clr_idx)]);  // R6

endmodule

// File: rtl/msi_gen.sv
module msi_gen
    import msi_gen_pkg::*;
#(
    parameter int N_VEC = NUM_VEC,
    parameter int V_W   = VEC_W,
    parameter int A_W   = ADDR_W,
    parameter int D_W   = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [15:0]    cfg_cmd,
    input  logic [31:0]    cfg_msi_ctl,
    input  logic [A_W-1:0] cfg_msi_addr,
    input  logic [D_W-1:0] cfg_msi_data,
    input  logic [N_VEC-1:0] cfg_msi_mask,
    input  logic           app_req,
    input  logic [V_W-1:0] app_vec,
    output logic           app_ack,
    output logic [1:0]     app_status,
    output logic           wr_valid,
    output logic [A_W-1:0] wr_addr,
    output logic [D_W-1:0] wr_data
);
    logic             msi_en;
    logic [N_VEC-1:0] in_range;
    logic [V_W-1:0]   low_mask;
    logic [N_VEC-1:0] release_ok;
    logic             grant_valid;
    logic [V_W-1:0]   grant_idx;

    logic             live;
    logic             live_ok;
    logic             live_masked;
    logic             set_en;
    logic [V_W-1:0]   send_vec;
    msi_wr_t          wr_d, wr_q;
    msi_resp_t        rsp_d, rsp_q;
    logic             legacy_off;

    // The legacy-disable bit belongs to the INTx path; MSI ignores it.
    assign legacy_off = cfg_cmd[CMD_INTX_DIS_BIT];

    msi_vec_window #(.N_VEC(N_VEC), .V_W(V_W)) u_win (
        .ctl_dw   (cfg_msi_ctl),
        .msi_en   (msi_en),
        .in_range (in_range),
        .low_mask (low_mask)
    );

    assign release_ok = ~cfg_msi_mask & in_range & {N_VEC{msi_en}};

    msi_pend_arb #(.N_VEC(N_VEC), .V_W(V_W)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .set_en      (set_en),
        .set_idx     (app_vec),
        .clr_en      (grant_valid),
        .clr_idx     (grant_idx),
        .release_ok  (release_ok),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    always_comb begin
        live        = app_req && !rsp_q.ack && !grant_valid;
        live_ok     = msi_en && in_range[app_vec];
        live_masked = cfg_msi_mask[app_vec];
        set_en      = live && live_ok && live_masked;
        send_vec    = grant_valid ? grant_idx : app_vec;

        wr_d.valid  = grant_valid || (live && live_ok && !live_masked);
        wr_d.addr   = cfg_msi_addr;
        wr_d.data   = compose_data(cfg_msi_data, send_vec, low_mask);

        rsp_d.ack   = live;
        if (!live_ok)        rsp_d.status = ST_DROP;
        else if (live_masked) rsp_d.status = ST_HELD;
        else                 rsp_d.status = ST_SENT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rsp_q <= '{ack: 1'b0, status: ST_SENT};
        end else begin
            wr_q  <= wr_d;
            rsp_q <= rsp_d;
        end
    end

    assign wr_valid   = wr_q.valid;
    assign wr_addr    = wr_q.addr;
    assign wr_data    = wr_q.data;
    assign app_ack    = rsp_q.ack;
    assign app_status = rsp_q.status;

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        app_ack |=> !app_ack);  // R8

    AST_SENT_WRITES: assert property (@(posedge clk) disable iff (rst)
        (app_ack && app_status == ST_SENT) |-> wr_valid);  // R2

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (app_ack && app_status == ST_DROP) |-> !wr_valid);  // R4

    AST_HELD_SILENT: assert property (@(posedge clk) disable iff (rst)
        (app_ack && app_status == ST_HELD) |-> !wr_valid);  // R5

    AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(cfg_msi_ctl[CTL_EN_BIT]));  // R3

    AST_PENDING_BEATS_LIVE: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && app_req) |=> !app_ack);  // R7

    AST_NO_UNUSED_STATUS: assert property (@(posedge clk) disable iff (rst)
        app_ack |-> (app_status != 2'd3));  // R2

    AST_LEGACY_BIT_KNOWN: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(legacy_off));  // R9

endmodule

// File: tb/tb_msi_gen.sv
module tb_msi_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_cmd = '0;
    logic [31:0] cfg_msi_ctl = '0;
    logic [63:0] cfg_msi_addr = 64'hFEE0_1234_0000_0A40;
    logic [15:0] cfg_msi_data = 16'h4A20;
    logic [31:0] cfg_msi_mask = '0;
    logic        app_req = 1'b0;
    logic [4:0]  app_vec = '0;
    logic        app_ack;
    logic [1:0]  app_status;
    logic        wr_valid;
    logic [63:0] wr_addr;
    logic [15:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    msi_gen dut (
        .clk(clk), .rst(rst), .cfg_cmd(cfg_cmd), .cfg_msi_ctl(cfg_msi_ctl),
        .cfg_msi_addr(cfg_msi_addr), .cfg_msi_data(cfg_msi_data),
        .cfg_msi_mask(cfg_msi_mask), .app_req(app_req), .app_vec(app_vec),
        .app_ack(app_ack), .app_status(app_status), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(input bit en, input int mme);
        logic [31:0] c;
        c = '0;
        c[16] = en;
        c[22:20] = 3'(mme);
        return c;
    endfunction

    // Full request handshake: drive, see ack, hold through ack cycle, release.
    task automatic do_req(input logic [4:0] v, input logic [1:0] exp_st,
                          input bit exp_wr, input logic [15:0] exp_data, input string tag);
        app_req = 1'b1;
        app_vec = v;
        @(negedge clk);
        chk(app_ack == 1'b1, {tag, " ack"}, 64'(app_ack), 64'd1);
        chk(app_status == exp_st, {tag, " status"}, 64'(app_status), 64'(exp_st));
        chk(wr_valid == exp_wr, {tag, " write"}, 64'(wr_valid), 64'(exp_wr));
        if (exp_wr) begin
            chk(wr_data == exp_data, {tag, " data"}, 64'(wr_data), 64'(exp_data));
            chk(wr_addr == cfg_msi_addr, {tag, " addr"}, wr_addr, cfg_msi_addr);
        end
        @(negedge clk);
        chk(app_ack == 1'b0 && wr_valid == 1'b0, "R8 held request not served twice",
            64'({app_ack, wr_valid}), 64'd0);
        app_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(app_ack == 0 && wr_valid == 0, "R1 outputs idle after reset", 64'({app_ack, wr_valid}), 64'd0);

        // R1: a pending bit made before reset must vanish.
        cfg_msi_ctl = ctl(1, 5);
        cfg_msi_mask = 32'h0000_0002;
        do_req(5'd1, 2'd1, 1'b0, 16'h0, "R5 masked before reset");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cfg_msi_mask = '0;
        @(negedge clk);
        chk(wr_valid == 0, "R1 pending cleared by reset", 64'(wr_valid), 64'd0);
        @(negedge clk);
        chk(wr_valid == 0, "R1 pending cleared by reset", 64'(wr_valid), 64'd0);

        // R2/R4: sweep every count code and every vector.
        for (int m = 0; m < 8; m++) begin
            int lg;
            int cnt;
            lg = (m > 5) ? 5 : m;
            cnt = 1 << lg;
            cfg_msi_ctl = ctl(1, m);
            for (int v = 0; v < 32; v++) begin
                if (v < cnt)
                    do_req(5'(v), 2'd0, 1'b1, cfg_msi_data | 16'(v), "R2 in-range send");
                else
                    do_req(5'(v), 2'd2, 1'b0, 16'h0, "R4 out-of-range drop");
            end
        end

        // R3: enable clear drops everything.
        cfg_msi_ctl = ctl(0, 5);
        do_req(5'd0, 2'd2, 1'b0, 16'h0, "R3 disabled drop");
        do_req(5'd17, 2'd2, 1'b0, 16'h0, "R3 disabled drop");

        // R9: legacy-disable bit has no effect.
        cfg_msi_ctl = ctl(1, 3);
        cfg_cmd = 16'h0400;
        do_req(5'd6, 2'd0, 1'b1, cfg_msi_data | 16'd6, "R9 legacy bit set");
        cfg_cmd = 16'h0000;
        do_req(5'd6, 2'd0, 1'b1, cfg_msi_data | 16'd6, "R9 legacy bit clear");

        // R5/R6/R7: two held vectors released together, lowest first.
        cfg_msi_mask = 32'h0000_0028;
        do_req(5'd5, 2'd1, 1'b0, 16'h0, "R5 held v5");
        do_req(5'd3, 2'd1, 1'b0, 16'h0, "R5 held v3");
        @(negedge clk);
        chk(wr_valid == 0, "R5 masked stays silent", 64'(wr_valid), 64'd0);
        cfg_msi_mask = '0;
        @(negedge clk);
        chk(wr_valid == 1 && wr_data == (cfg_msi_data | 16'd3), "R7 lowest pending first",
            64'({wr_valid, wr_data}), 64'({1'b1, cfg_msi_data | 16'd3}));
        @(negedge clk);
        chk(wr_valid == 1 && wr_data == (cfg_msi_data | 16'd5), "R6 second pending sent",
            64'({wr_valid, wr_data}), 64'({1'b1, cfg_msi_data | 16'd5}));
        @(negedge clk);
        chk(wr_valid == 0, "R6 pending sent only once", 64'(wr_valid), 64'd0);

        // R7: pending beats a live request.
        cfg_msi_mask = 32'h0000_0004;
        do_req(5'd2, 2'd1, 1'b0, 16'h0, "R5 held v2");
        cfg_msi_mask = '0;
        app_req = 1'b1;
        app_vec = 5'd6;
        @(negedge clk);
        chk(app_ack == 0 && wr_valid == 1 && wr_data == (cfg_msi_data | 16'd2),
            "R7 pending before live", 64'({app_ack, wr_valid, wr_data}),
            64'({1'b0, 1'b1, cfg_msi_data | 16'd2}));
        @(negedge clk);
        chk(app_ack == 1 && app_status == 2'd0 && wr_data == (cfg_msi_data | 16'd6),
            "R7 live served next", 64'({app_ack, app_status, wr_data}),
            64'({1'b1, 2'd0, cfg_msi_data | 16'd6}));
        @(negedge clk);
        chk(app_ack == 0 && wr_valid == 0, "R8 ack one cycle", 64'({app_ack, wr_valid}), 64'd0);
        app_req = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule